// File: doc/BRIEF.md
# Bidirectional General-Purpose Pin Port with Standby Isolation

This block is an eight-pin general-purpose I/O port for a small microcontroller. Software reaches it through a plain register bus that has an address, a write strobe, a read strobe and data. Two registers sit behind that bus. The output latch holds the value to drive, and the direction register chooses, pin by pin, whether the latch is driven. Any pin can be taken over by an on-chip peripheral while that peripheral's enable is high. A peripheral drive wins over the direction bit.

Each pad is modelled as three signals: a driven value, a drive enable and a sensed level. The sensed level passes through a two-flop synchroniser. A read of the data register returns this synchronised live pin level, never the latch contents. The latch is not cleared by reset. Software must therefore load the latch before it turns on a driver.

Two inputs come from the standby controller. `sleep_req` says the chip is in a stop or watch state, and `iso_sel` asks for pin isolation. When both are high, the port registers an isolation state on the next clock. In that state every driver is off, the input path is clamped to 0, and reads of the data register return 0. Isolation wins over both the peripheral override and the direction bits. Normal control returns on the first clock after the request drops.

Top module: `pio_port`

## Requirements
- R1: With its direction bit at 1 and no peripheral override, a pin has `pad_oe`=1, and `pad_out` carries the latch bit for that pin.
- R2: With its direction bit at 0 and no peripheral override, a pin has `pad_oe`=0 (high impedance).
- R3: A bus write with `bus_addr`=0 always updates the output latch, whatever the direction bits hold and even during isolation. The new value reaches a pin only once that pin's driver is enabled.
- R4: A read with `bus_addr`=0 returns the pin level as sampled through two flops. Data appears on `bus_rdata` after the clock edge on which `bus_rd` is high. A pin level is visible to a read issued two clocks after the pin changes.
- R5: While `periph_en[i]`=1 and no isolation is active, pin i has `pad_oe`=1 and `pad_out[i]`=`periph_out[i]`, whatever its direction bit holds.
- R6: A synchronous reset (`rst_n` low at a clock edge) clears every direction bit. All pins then read back as high-impedance inputs.
- R7: Reset leaves the output latch unchanged. A value written before reset is driven after reset once the direction bit is set again.
- R8: One clock after `sleep_req` and `iso_sel` are both sampled high, every `pad_oe` bit is 0, whatever the direction and peripheral enables hold.
- R9: While isolation is active, a read with `bus_addr`=0 returns 0, whatever the pad levels are.
- R10: On the first clock after the isolation request is sampled low, the drive enables and driven values are once again set by the direction bits and the peripheral enables.
- R11: A read with `bus_addr`=1 returns the stored direction bits.
- R12: `sleep_req` high with `iso_sel` low has no effect on any pin.
- R13: If the latch is written before the direction bit, no unknown value ever reaches a pin whose driver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 for the data latch, 1 for direction |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| periph_en | input | 8 | Per-pin peripheral override enable |
| periph_out | input | 8 | Per-pin peripheral drive value |
| sleep_req | input | 1 | Chip is in stop or watch state |
| iso_sel | input | 1 | Pin-state control: isolate pins while sleeping |
| pad_in | input | 8 | Sensed pad level |
| pad_out | output | 8 | Value driven to the pad |
| pad_oe | output | 8 | Pad driver enable |

## Verification
Most internal faults show up at the pads at once. A corrupted direction bit or isolation flag changes `pad_oe` on the next clock. A wrong latch bit shows on `pad_out` as soon as that pin's driver is enabled. Faults in the input path are slower to surface. A missing synchroniser stage, or a missing clamp, is only seen on `bus_rdata` one clock after a read, and that read has to come after the pad has changed. For this reason the bench drives an external level that differs from the latch before each data read.

// File: rtl/pio_pkg.sv
// Package: shared constants for the I/O port.
// Assumes a two-entry register map selected by a one-bit address.
package pio_pkg;
    localparam int unsigned REG_ADDR_W = 1;
    localparam logic [REG_ADDR_W-1:0] ADDR_LATCH = 1'b0;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIR   = 1'b1;
endpackage

// File: rtl/pio_regs.sv
// Module: output latch and direction register.
// Only the direction register is reset. The latch keeps its value across
// reset, so software must load it before it enables a driver.
module pio_regs
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]      wdata,
    output logic [WIDTH-1:0]      latch_q,
    output logic [WIDTH-1:0]      dir_q
);
    // Latch: loaded on every data write, with no reset.
    always_ff @(posedge clk) begin
        if (wr && addr == ADDR_LATCH) latch_q <= wdata;
    end

    // Direction: cleared on reset, loaded on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dir_q <= '0;
        else if (wr && addr == ADDR_DIR) dir_q <= wdata;
    end

    // R6: the edge that ends reset leaves every pin as an input.
    a_r6_dir_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dir_q == '0);

    // R11: direction bits change only through a direction write.
    a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr && addr == ADDR_DIR)) |-> $stable(dir_q));
endmodule

// File: rtl/pio_pad_ctl.sv
// Module: per-pin drive selection.
// Isolation wins over the peripheral override, and the peripheral override
// wins over the direction bit. The whole block is combinational.
module pio_pad_ctl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic             iso,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Pick the drive source and the enable for one pin.
        always_comb begin
            pad_out[i] = periph_en[i] ? periph_out[i] : latch[i];
            pad_oe[i]  = !iso && (periph_en[i] || dir[i]);
        end
    end
endmodule

// File: rtl/pio_in_sync.sv
// Module: input clamp and synchroniser.
// The pad level is gated to 0 before the first flop so that a floating pin
// cannot toggle logic during isolation. The synchronised result is also
// masked, so reads return 0 at once when isolation starts.
module pio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    input  logic             iso,
    output logic [WIDTH-1:0] pin_lvl
);
    logic [WIDTH-1:0] gated;
    logic [WIDTH-1:0] stg [STAGES];

    // Clamp the raw pad level while isolated.
    always_comb gated = pad_in & ~{WIDTH{iso}};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One synchroniser flop stage.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= gated;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
    end

    // Mask the synchronised level while isolated.
    always_comb pin_lvl = stg[STAGES-1] & ~{WIDTH{iso}};
endmodule

// File: rtl/pio_port.sv
// Module: top of the general-purpose I/O port.
// Assumes a single clock domain for the bus side, and that pad_in may change
// at any time. The isolation request is registered, so both the force and
// its release take effect one clock after the request changes.
module pio_port
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      periph_en,
    input  logic [WIDTH-1:0]      periph_out,
    input  logic                  sleep_req,
    input  logic                  iso_sel,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_lvl;
    logic             iso_q;

    pio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    pio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .dir(dir_q), .latch(latch_q), .periph_en(periph_en),
        .periph_out(periph_out), .iso(iso_q),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    pio_in_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .iso(iso_q),
        .pin_lvl(pin_lvl)
    );

    // Register the isolation request.
    always_ff @(posedge clk) begin
        if (!rst_n) iso_q <= 1'b0;
        else        iso_q <= sleep_req && iso_sel;
    end

    // Read data: the live pin level or the direction bits, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= (bus_addr == ADDR_DIR) ? dir_q : pin_lvl;
    end

    // R8: every driver is off one clock after an isolation request.
    a_r8_iso_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sleep_req && iso_sel)) |-> pad_oe == '0);

    // R9: a data read issued during isolation returns 0.
    a_r9_iso_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_rd && bus_addr == ADDR_LATCH && iso_q))
        |-> bus_rdata == '0);

    // R12: while no isolation was requested, pins follow the direction bits and peripheral enables.
    a_r12_no_iso_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sleep_req && iso_sel)) |-> pad_oe == (dir_q | periph_en));
endmodule

// File: tb/sim_pio_port.sv
`timescale 1ns/1ps
module sim_pio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] periph_en = '0, periph_out = '0;
    logic       sleep_req = 1'b0, iso_sel = 1'b0;
    logic [7:0] ext = '0, pad_in, pad_out, pad_oe;
    int         errors = 0, checks = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    // Pad model: a driven pin reflects its driver, otherwise the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    pio_port u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        repeat (2) @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R6 oe after reset", pad_oe, 8'h00);
        rd_reg(1'b1, rd); chk("R6 R11 dir after reset", rd, 8'h00);
    endtask

    task automatic t_input_mode();
        wr_reg(1'b0, 8'hA5);
        chk("R2 R3 input mode hiz", pad_oe, 8'h00);
        ext = 8'h3C;
        rd_reg(1'b0, rd); chk("R4 read pin not latch", rd, 8'h3C);
    endtask

    task automatic t_output_mode();
        wr_reg(1'b1, 8'hFF);
        chk("R1 oe", pad_oe, 8'hFF);
        chk("R1 R3 out", pad_out, 8'hA5);
        chk("R13 no X on driver", {7'd0, $isunknown(pad_out & pad_oe)}, 8'h00);
        rd_reg(1'b0, rd); chk("R4 read driven", rd, 8'hA5);
        rd_reg(1'b1, rd); chk("R11 dir readback", rd, 8'hFF);
        wr_reg(1'b1, 8'h0F); ext = 8'hF0;
        chk("R1 R2 mixed oe", pad_oe, 8'h0F);
        rd_reg(1'b0, rd); chk("R4 mixed read", rd, 8'hF5);
    endtask

    task automatic t_periph();
        wr_reg(1'b1, 8'h00); ext = 8'h00;
        periph_en = 8'h81; periph_out = 8'h80; #1;
        chk("R5 override oe", pad_oe, 8'h81);
        chk("R5 override out", pad_out & 8'h81, 8'h80);
        rd_reg(1'b0, rd); chk("R5 read periph value", rd, 8'h80);
        wr_reg(1'b1, 8'hFF);
        chk("R5 override beats dir", pad_out & 8'h81, 8'h80);
    endtask

    task automatic t_standby();
        ext = 8'hFF;
        @(negedge clk); sleep_req = 1'b1; iso_sel = 1'b1; #1;
        chk("R10 no force before edge", pad_oe, 8'hFF);
        @(negedge clk);
        chk("R8 forced hiz", pad_oe, 8'h00);
        rd_reg(1'b0, rd); chk("R9 clamped read", rd, 8'h00);
        wr_reg(1'b0, 8'h5A);
        chk("R8 R3 still hiz after write", pad_oe, 8'h00);
        @(negedge clk); sleep_req = 1'b0; #1;
        chk("R10 force held until edge", pad_oe, 8'h00);
        @(negedge clk);
        chk("R10 oe restored", pad_oe, 8'hFF);
        chk("R10 R3 out restored", pad_out, 8'hDA);
    endtask

    task automatic t_sleep_no_iso();
        @(negedge clk); iso_sel = 1'b0; sleep_req = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 sleep without iso", pad_oe, 8'hFF);
        sleep_req = 1'b0; periph_en = 8'h00;
    endtask

    task automatic t_latch_reset();
        wr_reg(1'b0, 8'h3C);
        do_reset();
        chk("R6 oe cleared by reset", pad_oe, 8'h00);
        wr_reg(1'b1, 8'hFF);
        chk("R7 latch kept across reset", pad_out, 8'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_input_mode();
        t_output_mode();
        t_periph();
        t_standby();
        t_sleep_no_iso();
        t_latch_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule